// File: doc/BRIEF.md
# Tributary Size Mismatch and Alarm Change Reporter

This block watches the two size bits carried in the first pointer byte of each tributary superframe. It compares them with the code expected for the configured tributary type. When the mismatch persists, it raises a size-error status. When the expected code returns for as long, it drops that status again.

The block also registers the loss-of-pointer and alarm-indication statuses it is given. Every change of any of the three statuses is caught in a sticky delta bit that holds until a processor clear strobe removes it. Each delta bit has its own mask bit, and the unmasked delta bits combine into one registered interrupt line. Register decoding sits outside; the clear and mask inputs arrive already decoded.

Top module: `trib_alarm_rpt`

## Requirements
- R1: The expected size code is 2'b11 when `size_sel_i` is 0 (1.5 Mbit/s tributary) and 2'b10 when `size_sel_i` is 1 (2 Mbit/s tributary). A superframe is a mismatch when `v1_ss_i` differs from that code.
- R2: `size_err_o` rises on the clock edge that samples the third consecutive mismatching superframe strobe. A matching strobe before the third restarts the run.
- R3: While `size_err_o` is 1, it falls on the edge that samples the third consecutive matching superframe strobe. A mismatching strobe restarts that run.
- R4: When `sf_strobe_i` is 0, `v1_ss_i` and `size_sel_i` have no effect on `size_err_o` or on the run counts.
- R5: `lop_o` and `ais_o` equal `lop_i` and `ais_i` as sampled on the previous clock edge.
- R6: A change of a status output sets its delta bit on the same edge. Bit 0 of `delta_o` tracks size error, bit 1 tracks LOP and bit 2 tracks AIS.
- R7: A delta bit stays set until the matching `clr_i` bit is 1 at a clock edge. A change on the same edge as its clear leaves the bit set.
- R8: `irq_o` is the OR of `delta_o & ~mask_i` sampled one edge earlier. A mask bit of 1 keeps its delta bit from raising the interrupt.
- R9: While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sf_strobe_i | input | 1 | Marks the cycle carrying a superframe's size bits |
| v1_ss_i | input | 2 | Received size bits |
| size_sel_i | input | 1 | Expected tributary type, 0 = 1.5 Mbit/s, 1 = 2 Mbit/s |
| lop_i | input | 1 | Loss-of-pointer status from the interpreter |
| ais_i | input | 1 | Alarm-indication status from the interpreter |
| mask_i | input | 3 | Interrupt mask per delta bit, 1 = masked |
| clr_i | input | 3 | Write-one-to-clear strobe per delta bit |
| size_err_o | output | 1 | Size-error status |
| lop_o | output | 1 | Registered loss-of-pointer status |
| ais_o | output | 1 | Registered alarm-indication status |
| delta_o | output | 3 | Sticky change bits {ais, lop, size} |
| irq_o | output | 1 | Registered interrupt |

## Verification
Each status output and each delta bit is due right after the edge that samples its cause. The interrupt is due one edge after that, because it is built from the delta bits already held together with the mask present at that edge. The bench drives inputs on the falling edge and advances its model by exactly one rising edge. It compares every output on the following falling edge, so each result is checked in the cycle it first becomes due.

// File: rtl/trib_alarm_pkg.sv
package trib_alarm_pkg;
  localparam int unsigned NSRC = 3;
  localparam int unsigned SRC_SIZE = 0;
  localparam int unsigned SRC_LOP  = 1;
  localparam int unsigned SRC_AIS  = 2;

  localparam logic [1:0] SS_T15 = 2'b11;
  localparam logic [1:0] SS_T2  = 2'b10;

  function automatic logic [1:0] exp_code(input logic sel);
    return sel ? SS_T2 : SS_T15;
  endfunction
endpackage

// File: rtl/trib_size_mon.sv
module trib_size_mon #(
  parameter int unsigned RUN_LEN = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sf_i,
  input  logic [1:0] ss_i,
  input  logic       sel_i,
  output logic       err_o,
  output logic       chg_o
);
  import trib_alarm_pkg::*;
  localparam int unsigned CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] RUN_LAST = CW'(RUN_LEN - 1);

  logic [CW-1:0] run_q, run_d;
  logic          err_q, err_d;
  logic          mis;

  assign mis = (ss_i != exp_code(sel_i));

  // run counts consecutive strobes pointing away from the current state
  always_comb begin
    err_d = err_q;
    run_d = run_q;
    if (sf_i) begin
      if (mis != err_q) begin
        if (run_q == RUN_LAST) begin
          err_d = ~err_q;
          run_d = '0;
        end else begin
          run_d = run_q + 1'b1;
        end
      end else begin
        run_d = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b0;
      run_q <= '0;
    end else begin
      err_q <= err_d;
      run_q <= run_d;
    end
  end

  assign err_o = err_q;
  assign chg_o = err_d ^ err_q;

  assert_run_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q < CW'(RUN_LEN));
  assert_no_strobe_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sf_i |=> $stable(err_q) && $stable(run_q));
  assert_rise_on_mis_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sf_i && mis && !err_q && run_q == RUN_LAST |=> err_q);
  assert_fall_on_match_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sf_i && !mis && err_q && run_q == RUN_LAST |=> !err_q);
endmodule

// File: rtl/trib_delta_bit.sv
module trib_delta_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic chg_i,
  input  logic clr_i,
  output logic q_o
);
  logic q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= 1'b0;
    else         q <= (q & ~clr_i) | chg_i;  // a change beats the clear
  end

  assign q_o = q;

  assert_chg_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_i |=> q_o);
  assert_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_o && !clr_i |=> q_o);
  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !chg_i |=> !q_o);
endmodule

// File: rtl/trib_alarm_rpt.sv
module trib_alarm_rpt #(
  parameter int unsigned RUN_LEN = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sf_strobe_i,
  input  logic [1:0] v1_ss_i,
  input  logic       size_sel_i,
  input  logic       lop_i,
  input  logic       ais_i,
  input  logic [2:0] mask_i,
  input  logic [2:0] clr_i,
  output logic       size_err_o,
  output logic       lop_o,
  output logic       ais_o,
  output logic [2:0] delta_o,
  output logic       irq_o
);
  import trib_alarm_pkg::*;

  logic            lop_q, ais_q, irq_q;
  logic            size_chg;
  logic [NSRC-1:0] chg, delta;

  trib_size_mon #(.RUN_LEN(RUN_LEN)) u_size (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sf_i  (sf_strobe_i),
    .ss_i  (v1_ss_i),
    .sel_i (size_sel_i),
    .err_o (size_err_o),
    .chg_o (size_chg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lop_q <= 1'b0;
      ais_q <= 1'b0;
    end else begin
      lop_q <= lop_i;
      ais_q <= ais_i;
    end
  end

  always_comb begin
    chg           = '0;
    chg[SRC_SIZE] = size_chg;
    chg[SRC_LOP]  = lop_i ^ lop_q;
    chg[SRC_AIS]  = ais_i ^ ais_q;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_delta
    trib_delta_bit u_bit (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .chg_i (chg[i]),
      .clr_i (clr_i[i]),
      .q_o   (delta[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(delta & ~mask_i);
  end

  assign lop_o   = lop_q;
  assign ais_o   = ais_q;
  assign delta_o = delta;
  assign irq_o   = irq_q;

  assert_lop_follow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lop_i |=> lop_o);
  assert_lop_change_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lop_i != lop_o) |=> delta_o[SRC_LOP]);
  assert_ais_change_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ais_i != ais_o) |=> delta_o[SRC_AIS]);
  assert_all_masked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_i) |=> !irq_o);
  assert_no_delta_no_irq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (delta_o == '0) |=> !irq_o);
endmodule

// File: tb/trib_alarm_rpt_test.sv
module trib_alarm_rpt_test;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       sf_strobe_i;
  logic [1:0] v1_ss_i;
  logic       size_sel_i;
  logic       lop_i, ais_i;
  logic [2:0] mask_i, clr_i;
  logic       size_err_o, lop_o, ais_o, irq_o;
  logic [2:0] delta_o;

  int checks = 0;
  int errors = 0;

  // bench model
  logic       m_serr, m_lop, m_ais, m_irq;
  logic [2:0] m_delta;
  int         m_run;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  trib_alarm_rpt uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sf_strobe_i(sf_strobe_i), .v1_ss_i(v1_ss_i),
    .size_sel_i(size_sel_i), .lop_i(lop_i), .ais_i(ais_i), .mask_i(mask_i),
    .clr_i(clr_i), .size_err_o(size_err_o), .lop_o(lop_o), .ais_o(ais_o),
    .delta_o(delta_o), .irq_o(irq_o)
  );

  function automatic logic [1:0] want_code(input logic sel);
    return sel ? 2'b10 : 2'b11;
  endfunction

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // advance model across one rising edge using the inputs now driven
  task automatic model_edge();
    logic [2:0] chg;
    logic       mis, nserr;
    chg = '0;
    nserr = m_serr;
    if (sf_strobe_i) begin
      mis = (v1_ss_i != want_code(size_sel_i));
      if (mis != m_serr) begin
        m_run++;
        if (m_run == 3) begin nserr = ~m_serr; m_run = 0; end
      end else m_run = 0;
    end
    chg[0] = nserr ^ m_serr;
    chg[1] = lop_i ^ m_lop;
    chg[2] = ais_i ^ m_ais;
    m_irq   = |(m_delta & ~mask_i);
    m_delta = (m_delta & ~clr_i) | chg;
    m_serr  = nserr;
    m_lop   = lop_i;
    m_ais   = ais_i;
  endtask

  task automatic step(input logic sf, input logic [1:0] ss, input logic sel,
                      input logic lop, input logic ais, input logic [2:0] msk,
                      input logic [2:0] clr);
    sf_strobe_i = sf; v1_ss_i = ss; size_sel_i = sel;
    lop_i = lop; ais_i = ais; mask_i = msk; clr_i = clr;
    model_edge();
    @(negedge clk_i);
    chk("R2/R3 size_err", {2'b0, size_err_o}, {2'b0, m_serr});
    chk("R5 lop/ais", {1'b0, ais_o, lop_o}, {1'b0, m_ais, m_lop});
    chk("R7 delta", delta_o, m_delta);
    chk("R8 irq", {2'b0, irq_o}, {2'b0, m_irq});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_ni = 1'b0; sf_strobe_i = 0; v1_ss_i = 0; size_sel_i = 0;
    lop_i = 0; ais_i = 0; mask_i = 0; clr_i = 0;
    m_serr = 0; m_lop = 0; m_ais = 0; m_irq = 0; m_delta = 0; m_run = 0;
    repeat (3) @(negedge clk_i);
    // R9: reset state
    chk("R9 reset", {size_err_o, lop_o, ais_o}, 3'b000);
    chk("R9 reset delta", delta_o, 3'b000);
    chk("R9 reset irq", {2'b0, irq_o}, 3'b000);
    rst_ni = 1'b1;

    // R1/R2: type 1.5 expects 11; 10 is a mismatch, idle cycles in between
    step(1, 2'b10, 0, 0, 0, 3'b000, 3'b000);
    step(0, 2'b11, 0, 0, 0, 3'b000, 3'b000);
    step(1, 2'b10, 0, 0, 0, 3'b000, 3'b000);
    chk("R2 not yet", {2'b0, size_err_o}, 3'b000);
    step(1, 2'b10, 0, 0, 0, 3'b000, 3'b000);
    chk("R1 R2 set after third", {2'b0, size_err_o}, 3'b001);
    chk("R6 size delta", delta_o, 3'b001);
    step(0, 2'b00, 0, 0, 0, 3'b000, 3'b000);
    chk("R8 irq follows delta", {2'b0, irq_o}, 3'b001);

    // R4: non-strobe cycles with matching code must not clear
    repeat (5) step(0, 2'b11, 0, 0, 0, 3'b000, 3'b000);
    chk("R4 ignored without strobe", {2'b0, size_err_o}, 3'b001);

    // R3: interrupted match run, then three matches clear
    step(1, 2'b11, 0, 0, 0, 3'b000, 3'b001);
    step(1, 2'b11, 0, 0, 0, 3'b000, 3'b000);
    step(1, 2'b01, 0, 0, 0, 3'b000, 3'b000);
    chk("R3 restart on mismatch", {2'b0, size_err_o}, 3'b001);
    repeat (3) step(1, 2'b11, 0, 0, 0, 3'b000, 3'b000);
    chk("R3 cleared", {2'b0, size_err_o}, 3'b000);

    // R1: type 2 expects 10; 11 mismatches, run broken after two
    step(0, 2'b00, 1, 0, 0, 3'b000, 3'b111);
    step(1, 2'b11, 1, 0, 0, 3'b000, 3'b000);
    step(1, 2'b11, 1, 0, 0, 3'b000, 3'b000);
    step(1, 2'b10, 1, 0, 0, 3'b000, 3'b000);
    step(1, 2'b11, 1, 0, 0, 3'b000, 3'b000);
    chk("R1 R2 broken run", {2'b0, size_err_o}, 3'b000);
    step(1, 2'b11, 1, 0, 0, 3'b000, 3'b000);
    step(1, 2'b11, 1, 0, 0, 3'b000, 3'b000);
    chk("R1 type2 mismatch set", {2'b0, size_err_o}, 3'b001);

    // R7: clear and change on the same edge, bit stays set
    step(0, 2'b10, 1, 0, 0, 3'b111, 3'b111);
    step(0, 2'b10, 1, 1, 0, 3'b111, 3'b010);
    chk("R7 change beats clear", delta_o, 3'b010);
    chk("R6 lop delta", {2'b0, lop_o}, 3'b001);
    // R8: masked delta raises no irq
    step(0, 2'b10, 1, 1, 0, 3'b111, 3'b000);
    chk("R8 masked", {2'b0, irq_o}, 3'b000);
    step(0, 2'b10, 1, 1, 1, 3'b101, 3'b000);
    step(0, 2'b10, 1, 1, 1, 3'b101, 3'b000);
    chk("R8 unmasked lop", {2'b0, irq_o}, 3'b001);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic       sel, bad;
      logic [1:0] ss;
      logic [2:0] msk, clr;
      sel = (i / 500) % 2 == 1;
      bad = ((i / 40) % 2 == 1) ? ($urandom % 5 != 0) : ($urandom % 5 == 0);
      ss  = bad ? (want_code(sel) ^ 2'(1 + $urandom % 3)) : want_code(sel);
      msk = ($urandom % 4 == 0) ? 3'($urandom) : mask_i;
      clr = ($urandom % 6 == 0) ? 3'($urandom) : 3'b000;
      step($urandom % 2 == 0, ss, sel,
           ($urandom % 15 == 0) ? ~lop_i : lop_i,
           ($urandom % 17 == 0) ? ~ais_i : ais_i, msk, clr);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule